// File: doc/BRIEF.md
# DMA Channel Address Generator

This block holds the running source and destination addresses of one DMA channel and moves them forward while a transfer is in progress. A transfer is opened with a start pulse that loads both starting addresses and checks the channel's setup. After that, the surrounding engine sends strobes that advance the addresses. One strobe marks each completed source read and one marks each completed destination write. A third marks the end of an inner (minor) loop and a fourth marks the end of the whole outer (major) loop.

Each per-access step adds a signed offset. The step can be confined to a power-of-two circular window, which makes ring buffers easy to build. The end of a minor loop can add a shared signed adjustment to either side or to both. The end of the major loop adds a separate signed correction to each side. Misaligned addresses, misaligned offsets and illegal size codes are caught when the transfer starts. Any of these faults freezes both addresses until the next start.

Top module: `dma_addr_gen`

## Requirements
- R1: After reset both addresses and all five fault flags are zero. A start pulse (`startEn`) loads `startSrcAddr`/`startDstAddr`, and the new values are visible on the next cycle. In that cycle the start pulse takes precedence over every advance strobe.
- R2: The size codes are 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes, 4 for 16 bytes and 5 for 32 bytes. At start, the codes 3, 6 or 7 on either side set `sizeFault`, and that side's alignment is then not checked.
- R3: `srcReadDone` adds the sign-extended 16-bit `srcStep` to the source address. `dstWriteDone` adds the sign-extended `dstStep` to the destination address.
- R4: With a window code n from 1 to 31, a per-access step writes only address bits [n-1:0] and leaves the upper bits unchanged, so the address wraps inside a 2^n-byte window. Code 0 lets the whole address take the sum.
- R5: `minorDone` adds the sign-extended 20-bit `minorAdj` to the source address when `minorSrcEn` is 1. It adds the same value to the destination address when `minorDstEn` is 1.
- R6: `majorDone` adds the full-width signed `srcLastAdj` to the source address and `dstLastAdj` to the destination address.
- R7: When several strobes arrive in one cycle, the windowed per-access step is applied first. The minor and major adjustments are then added at full width, outside the window.
- R8: At start, an address that is not a multiple of its transfer size sets `srcAddrFault` or `dstAddrFault` for that side.
- R9: At start, an offset that is not a multiple of its transfer size sets `srcStepFault` or `dstStepFault` for that side.
- R10: While any fault flag is set, both addresses hold whatever strobes arrive. The flags change only on a start pulse, which recomputes all of them.
- R11: In a cycle with no start pulse and no strobe, both addresses hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startEn | input | 1 | Load start addresses and check setup |
| startSrcAddr | input | 32 | Source start address |
| startDstAddr | input | 32 | Destination start address |
| srcStep | input | 16 | Signed per-read source offset |
| dstStep | input | 16 | Signed per-write destination offset |
| srcSize | input | 3 | Source transfer-size code |
| dstSize | input | 3 | Destination transfer-size code |
| srcWin | input | 5 | Source window code (0 = off) |
| dstWin | input | 5 | Destination window code (0 = off) |
| minorAdj | input | 20 | Signed minor-loop adjustment |
| minorSrcEn | input | 1 | Apply minor adjustment to source |
| minorDstEn | input | 1 | Apply minor adjustment to destination |
| srcLastAdj | input | 32 | Signed end-of-major source correction |
| dstLastAdj | input | 32 | Signed end-of-major destination correction |
| srcReadDone | input | 1 | A source read completed |
| dstWriteDone | input | 1 | A destination write completed |
| minorDone | input | 1 | A minor loop completed |
| majorDone | input | 1 | The major loop completed |
| srcAddr | output | 32 | Current source address |
| dstAddr | output | 32 | Current destination address |
| srcAddrFault | output | 1 | Source address misaligned at start |
| dstAddrFault | output | 1 | Destination address misaligned at start |
| srcStepFault | output | 1 | Source offset misaligned at start |
| dstStepFault | output | 1 | Destination offset misaligned at start |
| sizeFault | output | 1 | Illegal size code at start |

## Verification
The bench uses the default parameters: 32-bit addresses, 16-bit offsets, a 20-bit minor adjustment and 5-bit window codes. With these widths a window as small as 8 bytes can be tried, and so can the widest window of 31 bits, where a step across the top half of the address space must leave bit 31 unchanged. The 16-bit offsets and the 20-bit adjustment also allow negative values. These check that sign extension is correct and that wrapping below the window base works. The largest legal size of 32 bytes lies within the five low bits that the alignment checker examines.

// File: rtl/dag_pkg.sv
package dag_pkg;

  localparam int SIZE_CODE_W = 3;
  localparam int ALIGN_BITS  = 5;  // largest legal access is 32 bytes

  typedef struct packed {
    logic load;
    logic srcAdv;
    logic dstAdv;
    logic srcMinor;
    logic dstMinor;
    logic major;
  } dagStrobes_t;

  typedef struct packed {
    logic sizeBad;
    logic stepMis;
    logic addrMis;
  } alignRes_t;

  function automatic logic sizeLegal(input logic [SIZE_CODE_W-1:0] code);
    return (code == 3'd0) || (code == 3'd1) || (code == 3'd2) ||
           (code == 3'd4) || (code == 3'd5);
  endfunction

  function automatic logic [SIZE_CODE_W-1:0] sizeShift(input logic [SIZE_CODE_W-1:0] code);
    case (code)
      3'd1:    return 3'd1;
      3'd2:    return 3'd2;
      3'd4:    return 3'd4;
      3'd5:    return 3'd5;
      default: return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/dag_align_chk.sv
module dag_align_chk
  import dag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic [ADDR_W-1:0]      addr,
  input  logic [OFF_W-1:0]       step,
  input  logic [SIZE_CODE_W-1:0] sizeCode,
  output alignRes_t              res
);

  logic [ALIGN_BITS-1:0] lowMask;
  logic [SIZE_CODE_W-1:0] shiftAmt;
  logic legal;

  always_comb begin
    legal    = sizeLegal(sizeCode);
    shiftAmt = sizeShift(sizeCode);
    for (int b = 0; b < ALIGN_BITS; b++) begin
      lowMask[b] = legal && (b < int'(shiftAmt));
    end
    res.sizeBad = !legal;
    res.addrMis = |(addr[ALIGN_BITS-1:0] & lowMask);
    res.stepMis = |(step[ALIGN_BITS-1:0] & lowMask);
  end

endmodule

// File: rtl/dag_ctrl.sv
module dag_ctrl
  import dag_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startEn,
  input  logic        srcReadDone,
  input  logic        dstWriteDone,
  input  logic        minorDone,
  input  logic        majorDone,
  input  logic        minorSrcEn,
  input  logic        minorDstEn,
  input  alignRes_t   srcChk,
  input  alignRes_t   dstChk,
  output dagStrobes_t stb,
  output logic [4:0]  faultFlags
);

  logic halted;
  logic [4:0] startFlags;

  always_comb begin
    startFlags = {srcChk.sizeBad | dstChk.sizeBad, dstChk.stepMis, srcChk.stepMis,
                  dstChk.addrMis, srcChk.addrMis};
    halted     = |faultFlags;
  end

  always_ff @(posedge clk) begin
    if (!rstN)        faultFlags <= '0;
    else if (startEn) faultFlags <= startFlags;
  end

  always_comb begin
    stb.load     = startEn;
    stb.srcAdv   = !startEn && !halted && srcReadDone;
    stb.dstAdv   = !startEn && !halted && dstWriteDone;
    stb.srcMinor = !startEn && !halted && minorDone && minorSrcEn;
    stb.dstMinor = !startEn && !halted && minorDone && minorDstEn;
    stb.major    = !startEn && !halted && majorDone;
  end

  // R10
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !startEn |=> $stable(faultFlags));

endmodule

// File: rtl/dag_datapath.sv
module dag_datapath
  import dag_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 16,
  parameter int MINOR_W = 20,
  parameter int WIN_W   = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  dagStrobes_t        stb,
  input  logic [ADDR_W-1:0]  startSrcAddr,
  input  logic [ADDR_W-1:0]  startDstAddr,
  input  logic [OFF_W-1:0]   srcStep,
  input  logic [OFF_W-1:0]   dstStep,
  input  logic [WIN_W-1:0]   srcWin,
  input  logic [WIN_W-1:0]   dstWin,
  input  logic [MINOR_W-1:0] minorAdj,
  input  logic [ADDR_W-1:0]  srcLastAdj,
  input  logic [ADDR_W-1:0]  dstLastAdj,
  output logic [ADDR_W-1:0]  srcAddr,
  output logic [ADDR_W-1:0]  dstAddr
);

  localparam int LANES = 2;

  logic [ADDR_W-1:0]  laneAddr  [LANES];
  logic [ADDR_W-1:0]  laneStart [LANES];
  logic [OFF_W-1:0]   laneStep  [LANES];
  logic [WIN_W-1:0]   laneWin   [LANES];
  logic [ADDR_W-1:0]  laneLast  [LANES];
  logic               laneAdv   [LANES];
  logic               laneMinor [LANES];
  logic [ADDR_W-1:0]  minorExt;

  always_comb begin
    laneStart[0] = startSrcAddr;  laneStart[1] = startDstAddr;
    laneStep[0]  = srcStep;       laneStep[1]  = dstStep;
    laneWin[0]   = srcWin;        laneWin[1]   = dstWin;
    laneLast[0]  = srcLastAdj;    laneLast[1]  = dstLastAdj;
    laneAdv[0]   = stb.srcAdv;    laneAdv[1]   = stb.dstAdv;
    laneMinor[0] = stb.srcMinor;  laneMinor[1] = stb.dstMinor;
    minorExt     = {{(ADDR_W-MINOR_W){minorAdj[MINOR_W-1]}}, minorAdj};
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [ADDR_W-1:0] winMask;
    logic [ADDR_W-1:0] stepSum;
    logic [ADDR_W-1:0] stepped;
    logic [ADDR_W-1:0] nextAddr;

    always_comb begin
      for (int b = 0; b < ADDR_W; b++) begin
        winMask[b] = (laneWin[g] == '0) || (b < int'(laneWin[g]));
      end
      stepSum  = laneAddr[g] + {{(ADDR_W-OFF_W){laneStep[g][OFF_W-1]}}, laneStep[g]};
      stepped  = laneAdv[g] ? ((stepSum & winMask) | (laneAddr[g] & ~winMask)) : laneAddr[g];
      nextAddr = stepped + (laneMinor[g] ? minorExt : '0) + (stb.major ? laneLast[g] : '0);
    end

    always_ff @(posedge clk) begin
      if (!rstN)         laneAddr[g] <= '0;
      else if (stb.load) laneAddr[g] <= laneStart[g];
      else               laneAddr[g] <= nextAddr;
    end
  end

  assign srcAddr = laneAddr[0];
  assign dstAddr = laneAddr[1];

  // R1
  load_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> (srcAddr == $past(startSrcAddr)) && (dstAddr == $past(startDstAddr)));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.load && !stb.srcAdv && !stb.dstAdv && !stb.srcMinor && !stb.dstMinor && !stb.major
    |=> $stable(srcAddr) && $stable(dstAddr));

  // R4
  window_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.srcAdv && !stb.load && !stb.srcMinor && !stb.major && (srcWin != '0)
    |=> ((srcAddr ^ $past(srcAddr)) >> $past(srcWin)) == '0);

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dag_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 16,
  parameter int MINOR_W = 20,
  parameter int WIN_W   = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startEn,
  input  logic [ADDR_W-1:0]  startSrcAddr,
  input  logic [ADDR_W-1:0]  startDstAddr,
  input  logic [OFF_W-1:0]   srcStep,
  input  logic [OFF_W-1:0]   dstStep,
  input  logic [2:0]         srcSize,
  input  logic [2:0]         dstSize,
  input  logic [WIN_W-1:0]   srcWin,
  input  logic [WIN_W-1:0]   dstWin,
  input  logic [MINOR_W-1:0] minorAdj,
  input  logic               minorSrcEn,
  input  logic               minorDstEn,
  input  logic [ADDR_W-1:0]  srcLastAdj,
  input  logic [ADDR_W-1:0]  dstLastAdj,
  input  logic               srcReadDone,
  input  logic               dstWriteDone,
  input  logic               minorDone,
  input  logic               majorDone,
  output logic [ADDR_W-1:0]  srcAddr,
  output logic [ADDR_W-1:0]  dstAddr,
  output logic               srcAddrFault,
  output logic               dstAddrFault,
  output logic               srcStepFault,
  output logic               dstStepFault,
  output logic               sizeFault
);

  alignRes_t   srcChk, dstChk;
  dagStrobes_t stb;
  logic [4:0]  faultFlags;

  dag_align_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) srcChk_i (
    .addr(startSrcAddr), .step(srcStep), .sizeCode(srcSize), .res(srcChk));

  dag_align_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) dstChk_i (
    .addr(startDstAddr), .step(dstStep), .sizeCode(dstSize), .res(dstChk));

  dag_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .startEn(startEn),
    .srcReadDone(srcReadDone), .dstWriteDone(dstWriteDone),
    .minorDone(minorDone), .majorDone(majorDone),
    .minorSrcEn(minorSrcEn), .minorDstEn(minorDstEn),
    .srcChk(srcChk), .dstChk(dstChk), .stb(stb), .faultFlags(faultFlags));

  dag_datapath #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .MINOR_W(MINOR_W), .WIN_W(WIN_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb),
    .startSrcAddr(startSrcAddr), .startDstAddr(startDstAddr),
    .srcStep(srcStep), .dstStep(dstStep), .srcWin(srcWin), .dstWin(dstWin),
    .minorAdj(minorAdj), .srcLastAdj(srcLastAdj), .dstLastAdj(dstLastAdj),
    .srcAddr(srcAddr), .dstAddr(dstAddr));

  assign {sizeFault, dstStepFault, srcStepFault, dstAddrFault, srcAddrFault} = faultFlags;

  // R10
  fault_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (faultFlags != '0) && !startEn |=> $stable(srcAddr) && $stable(dstAddr));

endmodule

// File: tb/dma_addr_gen_tb_top.sv
`timescale 1ns/1ps
module dma_addr_gen_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic        startEn = 0, minorSrcEn = 0, minorDstEn = 0;
  logic        srcReadDone = 0, dstWriteDone = 0, minorDone = 0, majorDone = 0;
  logic [31:0] startSrcAddr = 0, startDstAddr = 0, srcLastAdj = 0, dstLastAdj = 0;
  logic [15:0] srcStep = 0, dstStep = 0;
  logic [2:0]  srcSize = 0, dstSize = 0;
  logic [4:0]  srcWin = 0, dstWin = 0;
  logic [19:0] minorAdj = 0;
  logic [31:0] srcAddr, dstAddr;
  logic        srcAddrFault, dstAddrFault, srcStepFault, dstStepFault, sizeFault;

  dma_addr_gen dut_i (.*);

  typedef struct { string tag; logic [31:0] s; logic [31:0] d; logic [4:0] f; } exp_t;
  exp_t sbQ[$];
  int checks = 0, errors = 0;
  bit finished = 0;
  logic [31:0] mSrc = 0, mDst = 0;
  logic [4:0]  mFlags = 0;

  function automatic int sizeBytes(input logic [2:0] c);
    case (c) 3'd0: return 1; 3'd1: return 2; 3'd2: return 4;
      3'd4: return 16; 3'd5: return 32; default: return 0; endcase
  endfunction

  function automatic logic [31:0] advance(input logic [31:0] a, input logic [15:0] off,
                                          input logic [4:0] n);
    logic [63:0] m;
    logic [31:0] sum;
    m   = (n == 0) ? 64'hFFFF_FFFF : ((64'd1 << n) - 64'd1);
    sum = a + {{16{off[15]}}, off};
    return (sum & m[31:0]) | (a & ~m[31:0]);
  endfunction

  function automatic logic [4:0] startFlags();
    int sb, db;
    logic [4:0] f;
    sb = sizeBytes(srcSize);
    db = sizeBytes(dstSize);
    f = '0;
    if (sb == 0 || db == 0) f[4] = 1;
    if (sb != 0 && (startSrcAddr % sb) != 0) f[0] = 1;
    if (db != 0 && (startDstAddr % db) != 0) f[1] = 1;
    if (sb != 0 && (int'(srcStep[4:0]) % sb) != 0) f[2] = 1;
    if (db != 0 && (int'(dstStep[4:0]) % db) != 0) f[3] = 1;
    return f;
  endfunction

  // driver: one clock, update the model, queue the expectation
  task automatic cyc(input string tag);
    logic [31:0] ns, nd, mx;
    exp_t e;
    @(posedge clk);
    #1;
    if (startEn) begin
      mSrc = startSrcAddr; mDst = startDstAddr; mFlags = startFlags();
    end else if (mFlags == 0) begin
      mx = {{12{minorAdj[19]}}, minorAdj};
      ns = srcReadDone ? advance(mSrc, srcStep, srcWin) : mSrc;
      nd = dstWriteDone ? advance(mDst, dstStep, dstWin) : mDst;
      if (minorDone && minorSrcEn) ns = ns + mx;
      if (minorDone && minorDstEn) nd = nd + mx;
      if (majorDone) begin ns = ns + srcLastAdj; nd = nd + dstLastAdj; end
      mSrc = ns; mDst = nd;
    end
    e.tag = tag; e.s = mSrc; e.d = mDst; e.f = mFlags;
    sbQ.push_back(e);
    @(negedge clk);
  endtask

  task automatic load(input logic [31:0] s, input logic [31:0] d, input string tag);
    startEn = 1; startSrcAddr = s; startDstAddr = d;
    cyc(tag);
    startEn = 0;
  endtask

  task automatic pulse(input bit rd, input bit wr, input bit mn, input bit mj, input string tag);
    srcReadDone = rd; dstWriteDone = wr; minorDone = mn; majorDone = mj;
    cyc(tag);
    srcReadDone = 0; dstWriteDone = 0; minorDone = 0; majorDone = 0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (sbQ.size() > 0) begin
      exp_t e;
      logic [4:0] af;
      e = sbQ.pop_front();
      af = {sizeFault, dstStepFault, srcStepFault, dstAddrFault, srcAddrFault};
      checks++;
      if (srcAddr !== e.s || dstAddr !== e.d || af !== e.f) begin
        errors++;
        $display("FAIL %s: got src=%h dst=%h flags=%b, expected src=%h dst=%h flags=%b",
                 e.tag, srcAddr, dstAddr, af, e.s, e.d, e.f);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    srcSize = 3'd2; dstSize = 3'd2; srcStep = 16'd4; dstStep = 16'hFFFC;
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (srcAddr !== 0 || dstAddr !== 0 ||
        {sizeFault, dstStepFault, srcStepFault, dstAddrFault, srcAddrFault} !== 0) begin
      errors++;
      $display("FAIL R1 reset: got src=%h dst=%h, expected 0", srcAddr, dstAddr);
    end
    rstN = 1;
    @(negedge clk);

    srcReadDone = 1; majorDone = 1; srcLastAdj = 32'h100;
    load(32'h1000, 32'h2000, "R1 start overrides strobes");
    srcReadDone = 0; majorDone = 0; srcLastAdj = 0;
    pulse(1, 0, 0, 0, "R3 source step");
    pulse(1, 0, 0, 0, "R3 source step again");
    pulse(0, 1, 0, 0, "R3 negative destination step");
    pulse(1, 1, 0, 0, "R3 both steps");
    pulse(0, 0, 0, 0, "R11 idle hold");
    pulse(0, 0, 0, 0, "R11 idle hold again");

    srcWin = 5'd4; dstWin = 5'd3;
    load(32'h100C, 32'h2000, "R1 load for window");
    pulse(1, 0, 0, 0, "R4 wrap up inside 16-byte window");
    pulse(0, 1, 0, 0, "R4 wrap below base of 8-byte window");
    srcWin = 5'd31;
    load(32'h7FFF_FFFC, 32'h2000, "R1 load for wide window");
    pulse(1, 0, 0, 0, "R4 31-bit window keeps bit 31");
    srcWin = 0; dstWin = 0;

    load(32'h1000, 32'h2000, "R1 load for minor");
    minorAdj = 20'hFFFC0; minorSrcEn = 1;
    pulse(0, 0, 1, 0, "R5 minor adjustment on source only");
    minorSrcEn = 0; minorDstEn = 1;
    pulse(0, 0, 1, 0, "R5 minor adjustment on destination only");
    minorDstEn = 0;
    pulse(0, 0, 1, 0, "R5 minor with both enables off");

    srcLastAdj = 32'hFFFF_FF00; dstLastAdj = 32'h40;
    pulse(0, 0, 0, 1, "R6 major corrections");
    srcLastAdj = 0; dstLastAdj = 0;

    srcWin = 5'd4;
    load(32'h100C, 32'h2000, "R1 load for combined");
    minorAdj = 20'h40; minorSrcEn = 1; srcLastAdj = 32'h8;
    pulse(1, 1, 1, 1, "R7 windowed step then full-width adjustments");
    minorSrcEn = 0; srcLastAdj = 0; srcWin = 0;

    srcSize = 3'd5; dstSize = 3'd4; srcStep = 16'd32; dstStep = 16'd16;
    load(32'h40, 32'h30, "R2 legal 32 and 16 byte sizes");
    pulse(1, 1, 0, 0, "R2 large steps advance");
    srcSize = 3'd3;
    load(32'h1000, 32'h2000, "R2 illegal source size code 3");
    pulse(1, 1, 0, 1, "R10 frozen on size fault");
    srcSize = 3'd2; dstSize = 3'd7; srcStep = 16'd4; dstStep = 16'd4;
    load(32'h1000, 32'h2000, "R2 illegal destination size code 7");
    srcSize = 3'd6; dstSize = 3'd2;
    load(32'h1000, 32'h2000, "R2 illegal source size code 6");
    srcSize = 3'd2;

    load(32'h1002, 32'h2000, "R8 source address misaligned");
    pulse(1, 0, 0, 0, "R10 frozen on address fault");
    load(32'h1000, 32'h2001, "R8 destination address misaligned");
    srcStep = 16'd2;
    load(32'h1000, 32'h2000, "R9 source step misaligned");
    dstStep = 16'hFFFE;
    load(32'h1000, 32'h2000, "R9 both steps misaligned");
    pulse(1, 1, 1, 1, "R10 frozen on step fault");
    srcStep = 16'd4; dstStep = 16'd4;
    load(32'h1000, 32'h2000, "R10 clean start clears flags");
    pulse(1, 1, 0, 0, "R10 steps resume after clean start");

    @(negedge clk);
    @(negedge clk);
    finish_run();
  end

endmodule